// File: doc/BRIEF.md
# Drive-Side Device Select and Status Register Port

This block is the device end of a parallel disk task-file interface, cut down to two registers: the device/head selection register and the status register. The host reaches both through a small register address bus with one-cycle read and write strobes. A write to the selection register latches the addressing mode, the device number and a four-bit head field. Outputs then present that field either as a cylinder/head/sector head number or as the top nibble of a 28-bit block address, as the current mode requires.

A command engine sits beside the block and is modelled only by ports. It marks the start of a command, marks its completion, and supplies the status bits to load at completion. The block owns the busy flag and the interrupt request line. While busy is set, a status read shows only the busy bit. When a command completes with interrupts enabled, a sticky request is raised. A status read from the selected device acknowledges it. A parameter-initialisation pulse from the engine stores the head field as the highest head number. After reset the block stays busy for a configurable number of cycles, and then reports itself ready.

Top module: `tf_devstat_port`

## Requirements
- R1: Register offset 6 selects the device/head register and offset 7 the status register. A read at any other offset leaves `host_rdata_oe` low, and a write at any other offset does not change the device/head contents.
- R2: On a write to offset 6, data bit 6 is latched as the addressing mode (1 = block addressing, 0 = cylinder/head/sector), bit 4 as the device number, and bits 3:0 as the head field. A read of offset 6 returns these bits in the same positions, with bits 7 and 5 reading 0.
- R3: `chs_head` equals the head field when the mode bit is 0, and is 0 otherwise. `lba_27_24` equals the head field when the mode bit is 1 and `cmd_ext` is 0, and is 0 otherwise.
- R4: `max_head` takes the current head field at the clock edge where `init_params` is high. It holds its value at every other edge.
- R5: The status byte carries busy at bit 7, ready at bit 6, device fault at bit 5, seek complete at bit 4, data request at bit 3 and error at bit 0, with bits 2:1 reading 0. At the edge where `cmd_done` is high, busy clears and the other five bits are loaded from the `done_*` inputs.
- R6: A `cmd_start` pulse without `cmd_done` sets busy at that edge. While busy is set, a status read returns 0x80.
- R7: `cmd_done` with `irq_en` high sets `intrq` from the next cycle. `cmd_done` with `irq_en` low leaves `intrq` low.
- R8: A status read by the selected device clears `intrq` at the edge that ends the read. A read of the device/head register does not clear it.
- R9: Reads are answered only when the latched device number equals `dev_strap`. Otherwise `host_rdata_oe` stays low, and a status read does not acknowledge the interrupt.
- R10: Reset clears `intrq` and sets busy. Busy stays set for exactly RESET_CYCLES clock edges after reset is released, and then the status byte reads 0x40. `cmd_start` and `cmd_done` are ignored during that wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 3 | Task-file register offset |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, 0 when not driven |
| host_rdata_oe | output | 1 | Read data is being driven |
| dev_strap | input | 1 | This device's number (0 or 1) |
| irq_en | input | 1 | Interrupts enabled |
| cmd_ext | input | 1 | Current command uses 48-bit addressing |
| cmd_start | input | 1 | Engine begins a command |
| cmd_done | input | 1 | Engine completes a command |
| init_params | input | 1 | Parameter-initialisation command executes |
| done_drdy | input | 1 | Ready bit to load at completion |
| done_fault | input | 1 | Device fault bit to load at completion |
| done_seek | input | 1 | Seek complete bit to load at completion |
| done_drq | input | 1 | Data request bit to load at completion |
| done_err | input | 1 | Error bit to load at completion |
| intrq | output | 1 | Interrupt request |
| sel_lba | output | 1 | Latched addressing mode |
| sel_dev | output | 1 | Latched device number |
| chs_head | output | 4 | Head number in cylinder/head/sector mode |
| lba_27_24 | output | 4 | Block address bits 27:24 in 28-bit mode |
| max_head | output | 4 | Stored highest head number |

## Verification
All 256 values are written to the device/head register, each under both settings of `cmd_ext`. This separates the mode bit from the device bit, and shows which of the two head outputs carries the field. It also shows that setting the device bit silences read-back. All 64 combinations of completion bits and interrupt enable are run through a start, done and read cycle. This catches a swapped status bit position, a leak of hidden bits while busy, and an interrupt that ignores the enable. Separate sequences pit an acknowledge from the wrong device or the wrong register against a correct one. The reset countdown is read back every cycle, with engine pulses injected during the wait.

// File: rtl/tf_pkg.sv
package tf_pkg;
   localparam int          TF_ADDR_W   = 3;
   localparam logic [2:0]  OFS_DEVHEAD = 3'd6;
   localparam logic [2:0]  OFS_STATUS  = 3'd7;
   localparam int          DH_LBA_BIT  = 6;
   localparam int          DH_DEV_BIT  = 4;
   localparam int          HEAD_BITS   = 4;
   localparam logic [7:0]  STAT_BUSY_ONLY = 8'h80;

   typedef struct packed {
      logic bsy;
      logic drdy;
      logic fault;
      logic seek_ok;
      logic xfer_req;
      logic err;
   } stat_t;

   // Place the status flags at their byte positions; bits 2:1 are always 0.
   function automatic logic [7:0] stat_byte(stat_t s);
      return {s.bsy, s.drdy, s.fault, s.seek_ok, s.xfer_req, 2'b00, s.err};
   endfunction
endpackage

// File: rtl/tf_devhead_reg.sv
module tf_devhead_reg #(
   parameter int HEAD_W = tf_pkg::HEAD_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        wdata,
   input  logic              init_go,
   input  logic              ext_cmd,
   output logic              lba_mode,
   output logic              dev_num,
   output logic [HEAD_W-1:0] head_raw,
   output logic [HEAD_W-1:0] chs_head,
   output logic [HEAD_W-1:0] lba_hi,
   output logic [HEAD_W-1:0] max_head
);
   import tf_pkg::*;

   if (HEAD_W != 4) begin : g_bad_head_w
      $error("tf_devhead_reg: head field must be four bits wide");
   end

   logic unused_wbits;
   assign unused_wbits = ^{wdata[7], wdata[5]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lba_mode <= 1'b0;
         dev_num  <= 1'b0;
         head_raw <= '0;
      end else if (wr_en) begin
         lba_mode <= wdata[DH_LBA_BIT];
         dev_num  <= wdata[DH_DEV_BIT];
         head_raw <= wdata[HEAD_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       max_head <= '0;
      else if (init_go) max_head <= head_raw;
   end

   always_comb begin
      chs_head = lba_mode ? '0 : head_raw;
      lba_hi   = (lba_mode && !ext_cmd) ? head_raw : '0;
   end

   a_r4_max_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !init_go |=> $stable(max_head));
   a_r3_exclusive_views: assert property (@(posedge clk) disable iff (!rst_n)
      !((chs_head != '0) && (lba_hi != '0)));
endmodule

// File: rtl/tf_status_reg.sv
module tf_status_reg #(
   parameter int RESET_CYCLES = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_start,
   input  logic          cmd_done,
   input  logic          done_drdy,
   input  logic          done_fault,
   input  logic          done_seek,
   input  logic          done_drq,
   input  logic          done_err,
   output tf_pkg::stat_t stat,
   output logic          eng_ok
);
   import tf_pkg::*;

   localparam int  CNT_W   = (RESET_CYCLES < 1) ? 1 : $clog2(RESET_CYCLES + 1);
   localparam logic BSY_RST = (RESET_CYCLES != 0);

   if (RESET_CYCLES < 0) begin : g_bad_cycles
      $error("tf_status_reg: RESET_CYCLES must not be negative");
   end

   logic wait_end;

   if (RESET_CYCLES == 0) begin : g_no_wait
      assign wait_end = 1'b0;
      assign eng_ok   = 1'b1;
   end else begin : g_wait
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cnt <= CNT_W'(RESET_CYCLES);
         else if (cnt != '0)  cnt <= cnt - 1'b1;
      end
      assign wait_end = (cnt == CNT_W'(1));
      assign eng_ok   = (cnt == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat      <= '0;
         stat.bsy  <= BSY_RST;
         stat.drdy <= !BSY_RST;
      end else if (wait_end) begin
         stat.bsy  <= 1'b0;
         stat.drdy <= 1'b1;
      end else if (eng_ok) begin
         if (cmd_done) begin
            stat.bsy      <= 1'b0;
            stat.drdy     <= done_drdy;
            stat.fault    <= done_fault;
            stat.seek_ok  <= done_seek;
            stat.xfer_req <= done_drq;
            stat.err      <= done_err;
         end else if (cmd_start) begin
            stat.bsy <= 1'b1;
         end
      end
   end

   a_r10_busy_during_wait: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_ok |-> stat.bsy);
   a_r6_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_ok && cmd_start && !cmd_done) |=> stat.bsy);
   a_r5_done_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_ok && cmd_done) |=> (!stat.bsy && stat.err == $past(done_err)
                                && stat.xfer_req == $past(done_drq)));
endmodule

// File: rtl/tf_irq_ctl.sv
module tf_irq_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic irq_en,
   input  logic ack,
   output logic intrq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  intrq <= 1'b0;
      else if (set_req && irq_en)  intrq <= 1'b1;
      else if (ack)                intrq <= 1'b0;
   end

   a_r7_raise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(intrq) |-> $past(set_req && irq_en));
   a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !(set_req && irq_en)) |=> !intrq);
endmodule

// File: rtl/tf_devstat_port.sv
module tf_devstat_port #(
   parameter int RESET_CYCLES    = 16,
   parameter bit MASK_WHILE_BUSY = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] host_addr,
   input  logic       host_wr,
   input  logic       host_rd,
   input  logic [7:0] host_wdata,
   output logic [7:0] host_rdata,
   output logic       host_rdata_oe,
   input  logic       dev_strap,
   input  logic       irq_en,
   input  logic       cmd_ext,
   input  logic       cmd_start,
   input  logic       cmd_done,
   input  logic       init_params,
   input  logic       done_drdy,
   input  logic       done_fault,
   input  logic       done_seek,
   input  logic       done_drq,
   input  logic       done_err,
   output logic       intrq,
   output logic       sel_lba,
   output logic       sel_dev,
   output logic [3:0] chs_head,
   output logic [3:0] lba_27_24,
   output logic [3:0] max_head
);
   import tf_pkg::*;

   localparam int HW = HEAD_BITS;

   logic          wr_dh, hit_dh, hit_st, selected, ack, eng_ok;
   logic [HW-1:0] head_raw;
   logic [7:0]    dh_byte, st_byte;
   stat_t         stat;

   assign wr_dh    = host_wr && (host_addr == OFS_DEVHEAD);
   assign hit_dh   = host_rd && (host_addr == OFS_DEVHEAD);
   assign hit_st   = host_rd && (host_addr == OFS_STATUS);
   assign selected = (sel_dev == dev_strap);
   assign ack      = hit_st && selected;

   tf_devhead_reg #(.HEAD_W(HW)) u_dh (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_dh), .wdata(host_wdata),
      .init_go(init_params), .ext_cmd(cmd_ext),
      .lba_mode(sel_lba), .dev_num(sel_dev), .head_raw(head_raw),
      .chs_head(chs_head), .lba_hi(lba_27_24), .max_head(max_head));

   tf_status_reg #(.RESET_CYCLES(RESET_CYCLES)) u_st (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_done(cmd_done),
      .done_drdy(done_drdy), .done_fault(done_fault), .done_seek(done_seek),
      .done_drq(done_drq), .done_err(done_err), .stat(stat), .eng_ok(eng_ok));

   tf_irq_ctl u_irq (
      .clk(clk), .rst_n(rst_n), .set_req(cmd_done && eng_ok),
      .irq_en(irq_en), .ack(ack), .intrq(intrq));

   always_comb begin
      dh_byte = '0;
      dh_byte[DH_LBA_BIT] = sel_lba;
      dh_byte[DH_DEV_BIT] = sel_dev;
      dh_byte[HW-1:0]     = head_raw;
   end

   if (MASK_WHILE_BUSY) begin : g_mask
      assign st_byte = stat.bsy ? STAT_BUSY_ONLY : stat_byte(stat);
   end else begin : g_raw
      assign st_byte = stat_byte(stat);
   end

   always_comb begin
      host_rdata_oe = (hit_dh || hit_st) && selected;
      if (!host_rdata_oe) host_rdata = '0;
      else if (hit_st)    host_rdata = st_byte;
      else                host_rdata = dh_byte;
   end

   a_r9_ack_only_selected_status: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(intrq) |-> $past(hit_st && host_rdata_oe));
   a_r9_oe_matches_strap: assert property (@(posedge clk) disable iff (!rst_n)
      host_rdata_oe |-> (u_dh.dev_num == dev_strap));
   a_r1_no_stray_oe: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr != OFS_DEVHEAD && host_addr != OFS_STATUS) |-> !host_rdata_oe);
endmodule

// File: tb/tf_devstat_port_test.sv
module tf_devstat_port_test;
   localparam int NRST = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [2:0] host_addr = '0;
   logic host_wr = 0, host_rd = 0;
   logic [7:0] host_wdata = '0, host_rdata;
   logic host_rdata_oe;
   logic dev_strap = 0, irq_en = 0, cmd_ext = 0, cmd_start = 0, cmd_done = 0;
   logic init_params = 0, done_drdy = 0, done_fault = 0, done_seek = 0;
   logic done_drq = 0, done_err = 0;
   logic intrq, sel_lba, sel_dev;
   logic [3:0] chs_head, lba_27_24, max_head;

   int n_tests = 0, n_fail = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   tf_devstat_port #(.RESET_CYCLES(NRST)) uut (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
      @(negedge clk); host_wr = 0;
   endtask

   // Starts at a negedge, samples 1 ns later, ends at the following negedge.
   task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic oe);
      host_addr = a; host_rd = 1; #1;
      d = host_rdata; oe = host_rdata_oe;
      @(negedge clk); host_rd = 0;
   endtask

   task automatic pulse_start();
      @(negedge clk); cmd_start = 1; @(negedge clk); cmd_start = 0;
   endtask

   task automatic pulse_done(input logic [4:0] b);
      @(negedge clk);
      {done_drdy, done_fault, done_seek, done_drq, done_err} = b;
      cmd_done = 1; @(negedge clk); cmd_done = 0;
   endtask

   task automatic do_reset();
      rst_n = 0; repeat (3) @(negedge clk); rst_n = 1;
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d; logic oe;
      do_reset();
      // R10: busy countdown, read every cycle
      chk(intrq == 0, "R10 intrq after reset", intrq, 0);
      for (int k = 0; k <= NRST; k++) begin
         rd(3'd7, d, oe);
         chk(oe && d == ((k < NRST) ? 8'h80 : 8'h40), "R10 countdown", d, (k < NRST) ? 8'h80 : 8'h40);
      end
      // R10: engine pulses during wait are ignored
      do_reset();
      irq_en = 1;
      pulse_start();
      pulse_done(5'b11111);
      repeat (NRST) @(negedge clk);
      chk(intrq == 0, "R10 done ignored in wait", intrq, 0);
      rd(3'd7, d, oe);
      chk(d == 8'h40, "R10 status after wait", d, 8'h40);

      // R1: other offsets
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), d, oe);
         chk(oe == 0, "R1 stray read oe", oe, 0);
      end
      wr(3'd6, 8'h05);
      wr(3'd5, 8'h4A);
      rd(3'd6, d, oe);
      chk(oe && d == 8'h05, "R1 stray write ignored", d, 8'h05);

      // R2/R3/R9: exhaustive device/head sweep
      for (int v = 0; v < 256; v++) begin
         for (int e = 0; e < 2; e++) begin
            logic [7:0] b; logic [3:0] hexp, lexp;
            b = 8'(v);
            cmd_ext = e[0];
            wr(3'd6, b);
            hexp = b[6] ? 4'h0 : b[3:0];
            lexp = (b[6] && !e[0]) ? b[3:0] : 4'h0;
            chk(sel_lba == b[6] && sel_dev == b[4], "R2 fields", {sel_lba, sel_dev}, {b[6], b[4]});
            chk(chs_head == hexp, "R3 chs head", chs_head, hexp);
            chk(lba_27_24 == lexp, "R3 lba hi", lba_27_24, lexp);
            rd(3'd6, d, oe);
            if (b[4]) chk(oe == 0, "R9 unselected read", oe, 0);
            else      chk(oe && d == (b & 8'h5F), "R2 readback", d, b & 8'h5F);
         end
      end
      cmd_ext = 0;
      wr(3'd6, 8'h00);

      // R4: max head capture
      wr(3'd6, 8'h0A);
      @(negedge clk); init_params = 1; @(negedge clk); init_params = 0;
      chk(max_head == 4'hA, "R4 capture", max_head, 4'hA);
      wr(3'd6, 8'h03);
      repeat (2) @(negedge clk);
      chk(max_head == 4'hA, "R4 hold", max_head, 4'hA);
      wr(3'd6, 8'h00);

      // R5/R6/R7/R8: status sweep
      for (int v = 0; v < 64; v++) begin
         logic [4:0] b; logic en; logic [7:0] sexp;
         b = v[4:0]; en = v[5];
         irq_en = en;
         pulse_start();
         rd(3'd7, d, oe);
         chk(d == 8'h80, "R6 busy mask", d, 8'h80);
         pulse_done(b);
         chk(intrq == en, "R7 intrq raise", intrq, en);
         sexp = {1'b0, b[4:1], 2'b00, b[0]};
         @(negedge clk);
         rd(3'd7, d, oe);
         chk(oe && d == sexp, "R5 status layout", d, sexp);
         chk(intrq == 0, "R8 ack on status read", intrq, 0);
      end

      // R8: device/head read does not acknowledge
      irq_en = 1;
      pulse_start(); pulse_done(5'b10000);
      @(negedge clk);
      rd(3'd6, d, oe);
      chk(intrq == 1, "R8 devhead read keeps intrq", intrq, 1);
      // R9: unselected status read does not acknowledge
      wr(3'd6, 8'h10);
      rd(3'd7, d, oe);
      chk(oe == 0 && intrq == 1, "R9 unselected no ack", {oe, intrq}, 2'b01);
      wr(3'd6, 8'h00);
      rd(3'd7, d, oe);
      chk(intrq == 0, "R9 selected ack", intrq, 0);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule